// File: doc/BRIEF.md
# Pin pull-resistor programming sequencer

This block holds the pull-resistor setting of every pad in a bank of 54 general-purpose pins. It drives a 2-bit pull code per pin to the pad drivers. Software cannot write a pin's pull code directly. It first writes a shared 2-bit pull mode into one control word. After that value has settled, it raises the clock bits of the pins it wants to change, in one of two per-bank clock words. It holds those bits for the settle interval and then writes them back to zero. Each selected pin takes the shared mode at that falling edge.

The block times both intervals in clock cycles. A pulse that is released too early changes nothing. Raising a clock bit too soon after a mode write gives a one-cycle setup-violation pulse. The stored pull codes can only be observed on the pad outputs. The register port reads back the mode word and the clock words, and nothing else.

Top module: `pull_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, every pin's pull code is 0 and `setup_err` is 0. Reads of the mode word and of both clock words return 0 until they are written.
- R2: A write to address 0x94 stores `bus_wdata[1:0]` as the pull mode and ignores the upper bits. A read of 0x94 returns the mode in bits 1:0 and zeros above. A mode write alone never changes any pad code.
- R3: Address 0x98 is the clock word for pins 0 to 31 and 0x9C is the clock word for pins 32 to 53. Pin n uses bit n%32 of word n/32. Bits with no pin behind them are dropped on write and read as 0.
- R4: Pull code 0 means no pull, 1 means pull-down and 2 means pull-up. Pin n's code is at `pad_pull[2n+1:2n]`. A pin takes the current mode when a clock-word write clears its bit, provided that write comes at least 150 cycles after the most recent write that set any bit in the same word. The new code is visible the cycle after the clearing write.
- R5: A clock bit cleared fewer than 150 cycles after the most recent bit-setting write to its word leaves that pin's code unchanged.
- R6: Mode value 3 is reserved. A pin released while the mode is 3 keeps its previous code, so no pin ever shows code 3.
- R7: `setup_err` pulses high for exactly the cycle after a clock-word write that sets a previously clear bit fewer than 150 cycles after the last mode write. In every other cycle it is low. Before any mode write after reset, the mode counts as settled.
- R8: Reads take effect at the clock edge, and `bus_rdata` holds the value from then on. Any address other than 0x94, 0x98 and 0x9C reads 0, so there is no path that reads back the pull codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_pull | output | 108 | Pull code of pin n at bits 2n+1:2n |
| setup_err | output | 1 | One-cycle setup-violation pulse |

## Verification
Every write takes effect at the clock edge that samples it. The pad codes and the setup flag change at that edge, and read data appears at the edge of the read. The bench therefore compares `pad_pull` and `setup_err` against its model on the falling edge right after each write, and `bus_rdata` on the falling edge right after each read. At the following falling edge it checks that the setup flag has dropped again. The model measures the setup and hold windows from the cycle numbers of the writes themselves. Directed cases place those windows at 149 and at 150 cycles, on both sides of the limit.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_code_e;

  localparam int WORD_W = 32;

  function automatic int bank_count(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int bank_lanes(input int pins, input int bank);
    int left;
    left = pins - WORD_W * bank;
    return (left > WORD_W) ? WORD_W : left;
  endfunction

endpackage

// File: rtl/pull_seq_regs.sv
module pull_seq_regs
  import pull_seq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_BANKS = 2,
  parameter int          SETTLE    = 150,
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  MODE_ADDR = 8'h94,
  parameter logic [7:0]  CLK_BASE  = 8'h98
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_en,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [1:0]                        mode_wdata,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_words,
  input  logic [NUM_BANKS-1:0]              bank_rise,
  output logic [NUM_BANKS-1:0]              bank_wr,
  output logic [1:0]                        mode_o,
  output logic [WORD_W-1:0]                 bus_rdata,
  output logic                              setup_err
);

  logic                 mode_hit;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [CNT_W-1:0]     setup_cnt;
  logic [WORD_W-1:0]    rd_val;
  logic                 wr_strobe;

  assign wr_strobe = bus_en && bus_we;
  assign mode_hit  = (bus_addr == ADDR_W'(MODE_ADDR));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign bank_hit[b] = (bus_addr == ADDR_W'(CLK_BASE + 4 * b));
    assign bank_wr[b]  = wr_strobe && bank_hit[b];
  end

  // Cycles since the last mode write, saturating at SETTLE
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= 2'd0;
      setup_cnt <= CNT_W'(SETTLE);
    end else if (wr_strobe && mode_hit) begin
      mode_o    <= mode_wdata;
      setup_cnt <= CNT_W'(1);
    end else if (setup_cnt < CNT_W'(SETTLE)) begin
      setup_cnt <= setup_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_err <= 1'b0;
    end else begin
      setup_err <= (|bank_rise) && (setup_cnt < CNT_W'(SETTLE));
    end
  end

  always_comb begin
    rd_val = '0;
    if (mode_hit) rd_val = WORD_W'(mode_o);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_val = bank_words[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/pull_seq_bank.sv
module pull_seq_bank
  import pull_seq_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int SETTLE = 150,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     wdata,
  input  logic [1:0]           mode,
  output logic [LANES-1:0]     word_o,
  output logic                 rise_o,
  output logic [2*LANES-1:0]   pull_o
);

  logic [LANES-1:0] rises;
  logic [LANES-1:0] falls;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_met;
  logic             mode_valid;

  assign rises      = wr_en ? (wdata & ~word_o) : '0;
  assign falls      = wr_en ? (word_o & ~wdata) : '0;
  assign rise_o     = |rises;
  assign hold_met   = (hold_cnt >= CNT_W'(SETTLE));
  assign mode_valid = (mode != PULL_RSVD);

  // Clock word and hold timer (restarted by any newly set bit)
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o   <= '0;
      hold_cnt <= CNT_W'(SETTLE);
    end else begin
      if (wr_en) word_o <= wdata;
      if (|rises) begin
        hold_cnt <= CNT_W'(1);
      end else if (hold_cnt < CNT_W'(SETTLE)) begin
        hold_cnt <= hold_cnt + CNT_W'(1);
      end
    end
  end

  // Pull codes: captured on a qualified falling clock bit
  always_ff @(posedge clk) begin
    if (rst) begin
      pull_o <= '0;
    end else if (hold_met && mode_valid) begin
      for (int i = 0; i < LANES; i++) begin
        if (falls[i]) pull_o[2*i +: 2] <= mode;
      end
    end
  end

endmodule

// File: rtl/pull_seq.sv
module pull_seq
  import pull_seq_pkg::*;
#(
  parameter int         NUM_PINS  = 54,
  parameter int         ADDR_W    = 8,
  parameter int         SETTLE    = 150,
  parameter logic [7:0] MODE_ADDR = 8'h94,
  parameter logic [7:0] CLK_BASE  = 8'h98
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [2*NUM_PINS-1:0] pad_pull,
  output logic                  setup_err
);

  localparam int NUM_BANKS = bank_count(NUM_PINS);
  localparam int CNT_W     = $clog2(SETTLE + 1);

  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words;
  logic [NUM_BANKS-1:0]             bank_rise;
  logic [NUM_BANKS-1:0]             bank_wr;
  logic [1:0]                       mode;

  pull_seq_regs #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .SETTLE    (SETTLE),
    .CNT_W     (CNT_W),
    .MODE_ADDR (MODE_ADDR),
    .CLK_BASE  (CLK_BASE)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .mode_wdata (bus_wdata[1:0]),
    .bank_words (bank_words),
    .bank_rise  (bank_rise),
    .bank_wr    (bank_wr),
    .mode_o     (mode),
    .bus_rdata  (bus_rdata),
    .setup_err  (setup_err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LANES = bank_lanes(NUM_PINS, b);
    logic [LANES-1:0]   word;
    logic [2*LANES-1:0] pulls;

    pull_seq_bank #(
      .LANES  (LANES),
      .SETTLE (SETTLE),
      .CNT_W  (CNT_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bank_wr[b]),
      .wdata  (bus_wdata[LANES-1:0]),
      .mode   (mode),
      .word_o (word),
      .rise_o (bank_rise[b]),
      .pull_o (pulls)
    );

    assign bank_words[b]                        = WORD_W'(word);
    assign pad_pull[2*WORD_W*b +: 2*LANES]      = pulls;
  end

endmodule

// File: rtl/pull_seq_chk.sv
module pull_seq_chk #(
  parameter int         NUM_PINS  = 54,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] MODE_ADDR = 8'h94,
  parameter logic [7:0] CLK_BASE  = 8'h98
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [2*NUM_PINS-1:0] pad_pull,
  input logic                  setup_err
);

  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;

  logic wr_any;
  logic clk_hit;
  logic rsvd_seen;

  assign wr_any = bus_en && bus_we;

  always_comb begin
    clk_hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(CLK_BASE + 4 * b)) clk_hit = 1'b1;
    end
  end

  always_comb begin
    rsvd_seen = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pad_pull[2*p +: 2] == 2'd3) rsvd_seen = 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (pad_pull == '0 && !setup_err)); // R1

  AST_MODE_WRITE_KEEPS_PULLS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_any && bus_addr == ADDR_W'(MODE_ADDR))) |-> $stable(pad_pull)); // R2

  AST_PULLS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_any)) |-> $stable(pad_pull)); // R4

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst)
    !rsvd_seen); // R6

  AST_ERR_AFTER_CLK_WRITE: assert property (@(posedge clk) disable iff (rst)
    setup_err |-> $past(wr_any && clk_hit)); // R7

endmodule

bind pull_seq pull_seq_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .MODE_ADDR (MODE_ADDR),
  .CLK_BASE  (CLK_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .pad_pull  (pad_pull),
  .setup_err (setup_err)
);

// File: tb/pull_seq_bench.sv
module pull_seq_bench;

  localparam int         CLK_PERIOD = 10;
  localparam int         NUM_PINS   = 54;
  localparam int         SETTLE     = 150;
  localparam logic [7:0] MODE_ADDR  = 8'h94;
  localparam logic [7:0] CLK_BASE   = 8'h98;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  bus_en = 1'b0;
  logic                  bus_we = 1'b0;
  logic [7:0]            bus_addr = '0;
  logic [31:0]           bus_wdata = '0;
  logic [31:0]           bus_rdata;
  logic [2*NUM_PINS-1:0] pad_pull;
  logic                  setup_err;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // model state
  logic [1:0]  m_pull [NUM_PINS];
  logic [1:0]  m_mode;
  logic [31:0] m_word [2];
  int          m_mode_t;
  int          m_rise_t [2];
  logic        m_err;

  pull_seq u_pull_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_pull  (pad_pull),
    .setup_err (setup_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] lane_mask(input int b);
    int lanes;
    lanes = NUM_PINS - 32 * b;
    if (lanes >= 32) return 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF >> (32 - lanes);
  endfunction

  function automatic logic [2*NUM_PINS-1:0] model_vector();
    logic [2*NUM_PINS-1:0] v;
    for (int p = 0; p < NUM_PINS; p++) v[2*p +: 2] = m_pull[p];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    m_err = 1'b0;
    if (a == MODE_ADDR) begin
      m_mode   = d[1:0];
      m_mode_t = cyc;
    end
    for (int b = 0; b < 2; b++) begin
      if (a == CLK_BASE + 8'(4 * b)) begin
        logic [31:0] nw, rises, falls;
        bit hold_ok;
        nw      = d & lane_mask(b);
        rises   = nw & ~m_word[b];
        falls   = m_word[b] & ~nw;
        m_err   = (rises != 0) && ((cyc - m_mode_t) < SETTLE);
        hold_ok = (cyc - m_rise_t[b]) >= SETTLE;
        for (int i = 0; i < 32; i++) begin
          if (32 * b + i < NUM_PINS && falls[i] && hold_ok && m_mode != 2'd3)
            m_pull[32 * b + i] = m_mode;
        end
        if (rises != 0) m_rise_t[b] = cyc;
        m_word[b] = nw;
      end
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    check(bus_rdata == exp, req, "read data", 128'(bus_rdata), 128'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pads(input string req);
    check(pad_pull == model_vector(), req, "pad codes", 128'(pad_pull), 128'(model_vector()));
  endtask

  task automatic check_err(input string req);
    check(setup_err == m_err, req, "setup flag", 128'(setup_err), 128'(m_err));
  endtask

  task automatic check_err_drops();
    @(negedge clk);
    check(setup_err == 1'b0, "R7", "flag after one cycle", 128'(setup_err), 128'(0));
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd7001);
    for (int p = 0; p < NUM_PINS; p++) m_pull[p] = 2'd0;
    m_mode = 2'd0; m_word[0] = '0; m_word[1] = '0;
    m_mode_t = -1000; m_rise_t[0] = -1000; m_rise_t[1] = -1000; m_err = 1'b0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(pad_pull == '0, "R1", "pads after reset", 128'(pad_pull), 128'(0));
    check(setup_err == 1'b0, "R1", "flag after reset", 128'(setup_err), 128'(0));
    bus_read(MODE_ADDR, 32'h0, "R1");
    bus_read(CLK_BASE, 32'h0, "R1");
    bus_read(CLK_BASE + 8'd4, 32'h0, "R1");

    // R2: mode write keeps low bits only, no pad change
    bus_write(MODE_ADDR, 32'hFFFF_FFFE);
    check_pads("R2");
    bus_read(MODE_ADDR, 32'h0000_0002, "R2");

    // R3: upper bank masked; R4: full release pulls all upper pins up
    idle(160);
    bus_write(CLK_BASE + 8'd4, 32'hFFFF_FFFF);
    check_err("R7");
    bus_read(CLK_BASE + 8'd4, 32'h003F_FFFF, "R3");
    idle(150);
    bus_write(CLK_BASE + 8'd4, 32'h0);
    check_pads("R4");
    check(pad_pull[107:106] == 2'd2, "R4", "pin 53 code", 128'(pad_pull[107:106]), 128'(2));
    check(pad_pull[63:0] == '0, "R3", "lower bank untouched", 128'(pad_pull[63:0]), 128'(0));

    // R5: hold of 149 cycles ignored, 150 accepted
    bus_write(MODE_ADDR, 32'h1);
    idle(160);
    bus_write(CLK_BASE, 32'h0000_0020);
    idle(147);
    bus_write(CLK_BASE, 32'h0);
    check_pads("R5");
    check(pad_pull[11:10] == 2'd0, "R5", "pin 5 after short pulse", 128'(pad_pull[11:10]), 128'(0));
    bus_write(CLK_BASE, 32'h0000_0020);
    idle(148);
    bus_write(CLK_BASE, 32'h0);
    check_pads("R4");
    check(pad_pull[11:10] == 2'd1, "R4", "pin 5 after full pulse", 128'(pad_pull[11:10]), 128'(1));

    // R7: setup of 149 cycles flagged, 150 not
    bus_write(MODE_ADDR, 32'h2);
    idle(147);
    bus_write(CLK_BASE, 32'h0000_0080);
    check_err("R7");
    check(setup_err == 1'b1, "R7", "flag on short setup", 128'(setup_err), 128'(1));
    check_err_drops();
    idle(150);
    bus_write(CLK_BASE, 32'h0);
    check_pads("R4");
    bus_write(MODE_ADDR, 32'h1);
    idle(148);
    bus_write(CLK_BASE, 32'h0000_0080);
    check_err("R7");
    check(setup_err == 1'b0, "R7", "no flag at 150", 128'(setup_err), 128'(0));
    idle(150);
    bus_write(CLK_BASE, 32'h0);
    check_pads("R4");

    // R6: reserved mode leaves pins alone
    bus_write(MODE_ADDR, 32'h3);
    idle(160);
    bus_write(CLK_BASE, 32'h0000_00A0);
    idle(155);
    bus_write(CLK_BASE, 32'h0);
    check_pads("R6");
    check(pad_pull[11:10] == 2'd1, "R6", "pin 5 kept", 128'(pad_pull[11:10]), 128'(1));

    // R8: unmapped addresses read zero
    bus_read(8'h00, 32'h0, "R8");
    bus_read(8'hA0, 32'h0, "R8");
    bus_read(MODE_ADDR, 32'h3, "R8");

    // random sequences
    for (int it = 0; it < 40; it++) begin
      int b;
      logic [31:0] bits;
      int gap_s, gap_h;
      b     = int'($urandom % 2);
      bits  = $urandom & $urandom & lane_mask(b);
      gap_s = ($urandom % 2) ? int'(148 + $urandom % 5) : int'($urandom % 148);
      gap_h = ($urandom % 2) ? int'(148 + $urandom % 5) : int'($urandom % 148);
      bus_write(MODE_ADDR, $urandom);
      idle(gap_s);
      bus_write(CLK_BASE + 8'(4 * b), bits);
      check_err("R7");
      idle(gap_h);
      bus_write(CLK_BASE + 8'(4 * b), bits & $urandom);
      check_pads("R4");
      bus_write(CLK_BASE + 8'(4 * b), 32'h0);
      check_pads("R5");
      bus_read(CLK_BASE + 8'(4 * b), m_word[b], "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule